// File: doc/BRIEF.md
# Triangle LFO Amplitude and Phase Modulator

This block is the low-frequency oscillator of one FM synthesis voice. It holds a fixed-point phase counter that moves forward by a programmable increment on each sample it accepts, as long as the oscillator is enabled. The integer part of that counter is a 7-bit step index. The block derives two values from that index. The first is an amplitude-modulation (AM) value shaped as a folded triangle. The second is a coarser phase-modulation (PM) step, which moves at a quarter of the step rate. Both values are refreshed only when the step index changes.

Each sample carries four operator attenuations. The block adds the AM value to each one, after a right shift chosen by a 2-bit sensitivity setting. Each operator has its own bit in an enable mask that decides whether it receives AM. Samples come in on a valid/ready stream and leave on another, with one register stage between them. A stalled consumer pushes back on the producer: `s_ready` is high only when the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output holds its value and no new sample is taken in. The PM frequency tables sit outside this block and take the PM step index from `m_pm`.

Top module: `lfo_tri_mod`

## Requirements
- R1: A sample is accepted on a rising edge where `s_valid` and `s_ready` are both high. Its result appears on `m_att`/`m_pm` with `m_valid` high after exactly that one edge. `s_ready` is high whenever `m_valid` is low or `m_ready` is high.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_att` and `m_pm` stay stable, `s_ready` is low, and the phase counter does not advance.
- R3: The phase counter is FRAC_W+7 bits wide and wraps modulo its width. On each accepted sample with `lfo_en` high, `lfo_inc` is added to it. The step index is the 7 counter bits above the FRAC_W fractional bits, and the updated counter value is the one applied to that same sample.
- R4: The stored AM value and PM step are recomputed only when an accepted sample changes the step index. After reset both are 0, so samples whose step stays 0 get no AM.
- R5: The AM value is formed from the low 6 bits of the step. Those bits are inverted when step bit 6 is 0, and the result is then doubled. This gives a range of 0 to 126.
- R6: The PM step is the step index shifted right by 2 (0 to 31). It is updated only when that quotient changes.
- R7: The AM amount added to an operator is the AM value shifted right by `am_sens` (0 to 3 places).
- R8: Operator k uses attenuation `s_att[k*ATT_W +: ATT_W]` and produces `m_att[k*(ATT_W+1) +: ATT_W+1]`. It receives AM only when `lfo_en` is high and `am_mask[k]` is 1. The output is one bit wider than the input, so the sum never wraps.
- R9: Bit 0 of every output attenuation is 0.
- R10: With `lfo_en` low, each output attenuation equals its input with bit 0 cleared, `m_pm` is 0, and the phase counter holds its value.
- R11: After reset the counter, AM value and PM step are 0, `m_valid` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lfo_en | input | 1 | Oscillator enable |
| lfo_inc | input | INC_W | Phase increment per accepted sample |
| am_sens | input | 2 | AM right-shift amount |
| am_mask | input | NUM_OP | Per-operator AM enable |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_att | input | NUM_OP*ATT_W | Operator attenuations in |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_att | output | NUM_OP*(ATT_W+1) | Modulated attenuations out |
| m_pm | output | 5 | PM step index |

## Verification
On every cycle the assertions check the stream rules: a stalled output holds steady and pushes back on the producer, and every output attenuation has bit 0 clear. They also check two pass-through cases. When the oscillator is disabled, each operator's attenuation passes through unmodified and PM reads 0. When an operator's mask bit is off, its attenuation also passes through unmodified. The remaining behaviours depend on the history of the phase counter, and only the bench's scenarios can show them. These are the folded triangle values, refresh only on a step change (including the zero AM left after reset), the PM quotient, the sensitivity shifts, the counter wrapping and counter hold, and the absence of a double advance across a stall.

// File: rtl/lfo_am_pkg.sv
package lfo_am_pkg;
  localparam int STEP_W = 7;
  localparam int AM_W   = 7;
  localparam int PM_W   = STEP_W - 2;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [AM_W-1:0]   am_t;
  typedef logic [PM_W-1:0]   pm_t;

  // folded triangle: rising half inverted, then doubled
  function automatic am_t fold_tri(input step_t s);
    logic [5:0] lo;
    lo = s[5:0];
    if (!s[6]) lo = ~lo;
    return {lo, 1'b0};
  endfunction

  function automatic pm_t pm_of(input step_t s);
    return s[STEP_W-1:2];
  endfunction
endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc
  import lfo_am_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int INC_W  = FRAC_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [INC_W-1:0]  inc,
  output step_t             step_nxt,
  output logic              step_chg
);
  localparam int CNT_W = FRAC_W + STEP_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_sum;
  step_t            step_cur;

  assign cnt_sum  = cnt_q + CNT_W'(inc);
  assign step_cur = cnt_q[CNT_W-1 -: STEP_W];
  assign step_nxt = cnt_sum[CNT_W-1 -: STEP_W];
  assign step_chg = adv && (step_nxt != step_cur);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_sum;
  end
endmodule

// File: rtl/lfo_shape.sv
module lfo_shape
  import lfo_am_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_chg,
  input  step_t step_nxt,
  output am_t   am_now,
  output pm_t   pm_now
);
  am_t  am_q;
  pm_t  pm_q;
  am_t  am_cand;
  pm_t  pm_cand;
  logic pm_chg;

  assign am_cand = fold_tri(step_nxt);
  assign pm_cand = pm_of(step_nxt);
  assign pm_chg  = step_chg && (pm_cand != pm_q);
  assign am_now  = step_chg ? am_cand : am_q;
  assign pm_now  = pm_chg ? pm_cand : pm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      am_q <= '0;
      pm_q <= '0;
    end else begin
      if (step_chg) am_q <= am_cand;
      if (pm_chg)   pm_q <= pm_cand;
    end
  end
endmodule

// File: rtl/lfo_op_scale.sv
module lfo_op_scale
  import lfo_am_pkg::*;
#(
  parameter int ATT_W = 10,
  localparam int OUT_W = ATT_W + 1
) (
  input  logic [ATT_W-1:0] att,
  input  am_t              am,
  input  logic [1:0]       sens,
  input  logic             use_am,
  output logic [OUT_W-1:0] att_out
);
  am_t              amt;
  logic [OUT_W-1:0] sum;

  always_comb begin
    amt = am >> sens;
    sum = OUT_W'(att);
    if (use_am) sum = sum + OUT_W'(amt);
    att_out = {sum[OUT_W-1:1], 1'b0};
  end
endmodule

// File: rtl/lfo_tri_mod.sv
module lfo_tri_mod
  import lfo_am_pkg::*;
#(
  parameter int NUM_OP = 4,
  parameter int ATT_W  = 10,
  parameter int FRAC_W = 8,
  parameter int INC_W  = FRAC_W + 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lfo_en,
  input  logic [INC_W-1:0]           lfo_inc,
  input  logic [1:0]                 am_sens,
  input  logic [NUM_OP-1:0]          am_mask,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [NUM_OP*ATT_W-1:0]    s_att,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [NUM_OP*(ATT_W+1)-1:0] m_att,
  output logic [4:0]                 m_pm
);
  localparam int OUT_W = ATT_W + 1;

  logic  take;
  logic  adv;
  step_t step_nxt;
  logic  step_chg;
  am_t   am_now;
  pm_t   pm_now;
  logic [NUM_OP*OUT_W-1:0] att_nxt;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign adv     = take && lfo_en;

  lfo_phase_acc #(.FRAC_W(FRAC_W), .INC_W(INC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .inc(lfo_inc),
    .step_nxt(step_nxt), .step_chg(step_chg)
  );

  lfo_shape u_shape (
    .clk(clk), .rst_n(rst_n), .step_chg(step_chg), .step_nxt(step_nxt),
    .am_now(am_now), .pm_now(pm_now)
  );

  for (genvar k = 0; k < NUM_OP; k++) begin : g_op
    lfo_op_scale #(.ATT_W(ATT_W)) u_op (
      .att(s_att[k*ATT_W +: ATT_W]),
      .am(am_now),
      .sens(am_sens),
      .use_am(lfo_en && am_mask[k]),
      .att_out(att_nxt[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_att   <= '0;
      m_pm    <= '0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_att   <= att_nxt;
      m_pm    <= lfo_en ? pm_now : '0;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lfo_tri_mod_chk.sv
module lfo_tri_mod_chk #(
  parameter int NUM_OP = 4,
  parameter int ATT_W  = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        lfo_en,
  input logic [NUM_OP-1:0]           am_mask,
  input logic                        s_valid,
  input logic                        s_ready,
  input logic [NUM_OP*ATT_W-1:0]     s_att,
  input logic                        m_valid,
  input logic                        m_ready,
  input logic [NUM_OP*(ATT_W+1)-1:0] m_att,
  input logic [4:0]                  m_pm
);
  localparam int OUT_W = ATT_W + 1;
  logic [NUM_OP-1:0] lsbs;

  always_comb
    for (int k = 0; k < NUM_OP; k++) lsbs[k] = m_att[k*OUT_W];

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_att) && $stable(m_pm)));

  p_stall_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  p_lsb_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (lsbs == '0));

  p_off_pm_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !lfo_en) |=> (m_valid && m_pm == 5'd0));

  for (genvar k = 0; k < NUM_OP; k++) begin : g_chk
    p_off_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && !lfo_en) |=>
        (m_att[k*OUT_W +: OUT_W] ==
         {1'b0, $past(s_att[k*ATT_W +: ATT_W]) & ~ATT_W'(1)}));

    p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && !am_mask[k]) |=>
        (m_att[k*OUT_W +: OUT_W] ==
         {1'b0, $past(s_att[k*ATT_W +: ATT_W]) & ~ATT_W'(1)}));
  end
endmodule

bind lfo_tri_mod lfo_tri_mod_chk #(.NUM_OP(NUM_OP), .ATT_W(ATT_W)) u_chk (.*);

// File: tb/sim_lfo_tri_mod.sv
`timescale 1ns/1ps
module sim_lfo_tri_mod;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lfo_en;
  logic [14:0] lfo_inc;
  logic [1:0]  am_sens;
  logic [3:0]  am_mask;
  logic        s_valid;
  logic        s_ready;
  logic [39:0] s_att;
  logic        m_valid;
  logic        m_ready;
  logic [43:0] m_att;
  logic [4:0]  m_pm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lfo_tri_mod u0 (.*);

  typedef struct packed {
    logic        en;
    logic [14:0] inc;
    logic [1:0]  sens;
    logic [3:0]  mask;
    logic [9:0]  a3, a2, a1, a0;
    logic [10:0] e3, e2, e1, e0;
    logic [4:0]  pm;
  } vec_t;

  // expected values worked out from R3..R10, counter starting at 0
  localparam vec_t VEC [9] = '{
    '{1'b1, 15'h0040, 2'd0, 4'hF, 10'd401, 10'd300, 10'd200, 10'd100, 11'd400,  11'd300, 11'd200, 11'd100, 5'd0},
    '{1'b1, 15'h00C0, 2'd0, 4'hF, 10'd401, 10'd300, 10'd200, 10'd100, 11'd524,  11'd424, 11'd324, 11'd224, 5'd0},
    '{1'b1, 15'h0300, 2'd1, 4'h5, 10'd401, 10'd300, 10'd200, 10'd100, 11'd400,  11'd358, 11'd200, 11'd158, 5'd1},
    '{1'b0, 15'h1000, 2'd0, 4'hF, 10'd401, 10'd300, 10'd200, 10'd101, 11'd400,  11'd300, 11'd200, 11'd100, 5'd0},
    '{1'b1, 15'h3C00, 2'd0, 4'hF, 10'd401, 10'd300, 10'd200, 10'd100, 11'd400,  11'd300, 11'd200, 11'd100, 5'd16},
    '{1'b1, 15'h3F00, 2'd3, 4'h8, 10'd401, 10'd300, 10'd200, 10'd100, 11'd416,  11'd300, 11'd200, 11'd100, 5'd31},
    '{1'b1, 15'h0080, 2'd2, 4'h2, 10'd401, 10'd300, 10'd200, 10'd100, 11'd400,  11'd300, 11'd230, 11'd100, 5'd31},
    '{1'b1, 15'h0080, 2'd0, 4'hF, 10'd401, 10'd300, 10'd200, 10'd100, 11'd526,  11'd426, 11'd326, 11'd226, 5'd0},
    '{1'b1, 15'h0100, 2'd0, 4'hF, 10'd1023,10'd1023,10'd1023,10'd1023,11'd1146, 11'd1146,11'd1146,11'd1146,5'd0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; lfo_en = 1'b0; lfo_inc = '0; am_sens = '0; am_mask = '0;
    s_valid = 1'b0; s_att = '0; m_ready = 1'b1;
    do_reset();
    check("R11 m_valid after reset", m_valid, 0);
    check("R11 s_ready after reset", s_ready, 1);
    check("R11 m_pm after reset", m_pm, 0);

    // vector walk: R3 R4 R5 R6 R7 R8 R9 R10, one-cycle latency R1
    for (int i = 0; i < 9; i++) begin
      lfo_en = VEC[i].en; lfo_inc = VEC[i].inc; am_sens = VEC[i].sens;
      am_mask = VEC[i].mask;
      s_att = {VEC[i].a3, VEC[i].a2, VEC[i].a1, VEC[i].a0};
      s_valid = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      check($sformatf("R1 valid v%0d", i), m_valid, 1);
      check($sformatf("R5 op0 v%0d", i), m_att[10:0],  VEC[i].e0);
      check($sformatf("R7 op1 v%0d", i), m_att[21:11], VEC[i].e1);
      check($sformatf("R8 op2 v%0d", i), m_att[32:22], VEC[i].e2);
      check($sformatf("R9 op3 v%0d", i), m_att[43:33], VEC[i].e3);
      check($sformatf("R6 pm v%0d", i), m_pm, VEC[i].pm);
      @(negedge clk);
      check($sformatf("R1 drained v%0d", i), m_valid, 0);
    end

    // R2 back-pressure, R4 first change after reset
    do_reset();
    m_ready = 1'b0;
    lfo_en = 1'b1; lfo_inc = 15'h0100; am_sens = 2'd0; am_mask = 4'hF;
    s_att = {4{10'd10}};
    s_valid = 1'b1;
    @(negedge clk);
    s_att = {4{10'd20}};
    check("R2 stalled valid", m_valid, 1);
    check("R2 ready low in stall", s_ready, 0);
    check("R4 first step AM", m_att[10:0], 134);
    @(negedge clk);
    check("R2 held output", m_att[10:0], 134);
    check("R2 ready still low", s_ready, 0);
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R2 next sample after stall", m_att[10:0], 142);
    check("R3 no double advance pm", m_pm, 0);
    @(negedge clk);
    check("R1 empty after drain", m_valid, 0);

    // R4: step unchanged after reset keeps AM at 0
    do_reset();
    lfo_en = 1'b1; lfo_inc = 15'h00FF; am_mask = 4'hF; s_att = {4{10'd50}};
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R4 no refresh without step change", m_att[10:0], 50);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule